// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Controller

This block lets any of up to four processor cores ring a doorbell on another core and hand it a 16-bit message. Every core sees a pair of 32-bit words on a simple word-addressed register bus. One is a command word that it writes. The other is a mailbox word that it reads. Each core also has its own level interrupt output. A core raises an interrupt on a peer by writing a command that carries the peer's index, a "raise" flag and the payload. The peer sees its line go high, reads its mailbox to learn who rang and what they sent, then writes a command with the "clear" flag to drop its line.

There is one mailbox slot per core and no queue. A newer message replaces an older one that has not yet been cleared. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset every command word and every mailbox word reads as zero, and every interrupt output is low.
- R2: The address of a register is byte address = core*8 + sel*4. Here sel=0 is the command word and sel=1 is the mailbox word. A write to a core's command word stores all 32 bits, and a read returns them unchanged.
- R3: A command with bit 30 (raise) set and bits 29:16 naming a destination core below NUM_CORES loads that core's mailbox on the next edge. The mailbox is loaded with bit 30 = 1 (pending), bits 29:16 = the writing core's index and bits 15:0 = the command's bits 15:0. All other mailbox bits are 0. The destination's interrupt output goes high on the same edge.
- R4: A command with bit 31 (clear) set clears the writing core's pending bit and drops its interrupt output. The mailbox's sender and payload fields are kept.
- R5: When raise and clear are both set, raise is applied before clear. Targeting oneself therefore leaves pending 0 with the new sender and payload. Targeting another core raises that core and clears the writer.
- R6: A write to any mailbox word changes no register and no interrupt output.
- R7: A raise aimed at a core that is already pending replaces its sender and payload, and its interrupt output stays high.
- R8: A raise whose destination index is NUM_CORES or greater changes no mailbox and no interrupt output. The command word is still stored.
- R9: An access whose core index is NUM_CORES or above reads zero, and a write to it changes nothing.
- R10: Each interrupt output is a registered level that always equals bit 30 of its core's mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| core_irq | output | NUM_CORES | Per-core interrupt level |

## Verification
The bench sweeps every sender against every destination, including two destinations past the core count. It runs each pair with raise alone, raise with clear and clear alone, and compares every register and line after every write. The sweep catches a design that applies clear before raise: a self-targeted raise-and-clear would then leave the line stuck high. It also catches a design that wipes the payload on clear, and one that lets an out-of-range destination alias onto a low core through truncated index bits. Separate cases write every mailbox word with all ones, address unmapped slots, and raise an interrupt on a core that is already pending. A design that lets mailbox writes through, or that pulses the line low on an overwrite, shows up there.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W   = 32;
  localparam int CLR_BIT  = 31;
  localparam int RAISE_BIT = 30;
  localparam int PEND_BIT = 30;
  localparam int ID_LSB   = 16;
  localparam int ID_W     = 14;
  localparam int MSG_W    = 16;

  function automatic logic [ID_W-1:0] cmd_dest(input logic [WORD_W-1:0] w);
    return w[ID_LSB +: ID_W];
  endfunction

  function automatic logic [WORD_W-1:0] mbox_word(input logic [ID_W-1:0] src,
                                                   input logic [MSG_W-1:0] msg);
    return {1'b0, 1'b1, src, msg};
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NUM_CORES-1:0] cmd_wr,
  output logic [NUM_CORES-1:0] raise_hit,
  output logic [NUM_CORES-1:0] clr_hit,
  output logic [ID_W-1:0]      src_id,
  output logic                 slot_ok,
  output logic                 sel_mbox
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] slot_idx;
  logic [ID_W-1:0]  dest;
  logic             dest_ok;
  logic             any_cmd;

  assign slot_idx = addr[ADDR_W-1:3];
  assign sel_mbox = addr[2];
  assign slot_ok  = 32'(slot_idx) < 32'(NUM_CORES);
  assign src_id   = ID_W'(slot_idx);
  assign dest     = cmd_dest(wdata);
  assign dest_ok  = 32'(dest) < 32'(NUM_CORES);
  assign any_cmd  = we && slot_ok && !sel_mbox;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
    assign cmd_wr[i]    = any_cmd && (32'(slot_idx) == i);
    assign raise_hit[i] = any_cmd && wdata[RAISE_BIT] && dest_ok && (32'(dest) == i);
    assign clr_hit[i]   = cmd_wr[i] && wdata[CLR_BIT];
  end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              raise_hit,
  input  logic              clr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ID_W-1:0]   src_id,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] mbox_q,
  output logic              irq_q
);
  logic [WORD_W-1:0] mbox_nxt;

  always_comb begin
    mbox_nxt = mbox_q;
    if (raise_hit) mbox_nxt = mbox_word(src_id, wdata[MSG_W-1:0]);
    if (clr_hit)   mbox_nxt[PEND_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mbox_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= wdata;
      mbox_q <= mbox_nxt;
      irq_q  <= mbox_nxt[PEND_BIT];
    end
  end

  // R2
  cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_q == $past(wdata));
  // R3
  raise_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_hit && !clr_hit |=> irq_q && mbox_q[PEND_BIT] &&
      mbox_q[MSG_W-1:0] == $past(wdata[MSG_W-1:0]) &&
      mbox_q[ID_LSB +: ID_W] == $past(src_id));
  // R4
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !irq_q && !mbox_q[PEND_BIT]);
  // R4
  clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !raise_hit |=> mbox_q[29:0] == $past(mbox_q[29:0]));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_hit && !clr_hit |=> $stable(mbox_q) && $stable(irq_q));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == mbox_q[PEND_BIT]);
endmodule

// File: rtl/ipi_rdmux.sv
module ipi_rdmux
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  cmd_regs,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  mbox_regs,
  output logic [WORD_W-1:0]                 rdata
);
  localparam int IDX_W = ADDR_W - 3;
  logic [IDX_W-1:0] slot_idx;
  assign slot_idx = addr[ADDR_W-1:3];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (32'(slot_idx) == i) rdata = addr[2] ? mbox_regs[i] : cmd_regs[i];
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] core_irq
);
  logic [NUM_CORES-1:0]             cmd_wr, raise_hit, clr_hit;
  logic [ID_W-1:0]                  src_id;
  logic                             slot_ok, sel_mbox;
  logic [NUM_CORES-1:0][WORD_W-1:0] cmd_regs, mbox_regs;
  logic                             mbox_write;

  assign mbox_write = bus_we && sel_mbox;

  ipi_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cmd_wr(cmd_wr), .raise_hit(raise_hit), .clr_hit(clr_hit),
    .src_id(src_id), .slot_ok(slot_ok), .sel_mbox(sel_mbox));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    ipi_slot u_slot (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_wr[i]),
      .raise_hit(raise_hit[i]), .clr_hit(clr_hit[i]),
      .wdata(bus_wdata), .src_id(src_id),
      .cmd_q(cmd_regs[i]), .mbox_q(mbox_regs[i]), .irq_q(core_irq[i]));
  end

  ipi_rdmux #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_rd (
    .addr(bus_addr), .cmd_regs(cmd_regs), .mbox_regs(mbox_regs),
    .rdata(bus_rdata));

  // R6
  mbox_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_write |=> $stable(core_irq) && $stable(mbox_regs) && $stable(cmd_regs));
  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !slot_ok |=> $stable(core_irq) && $stable(mbox_regs) && $stable(cmd_regs));
endmodule

// File: tb/test_ipi_ctrl.sv
module test_ipi_ctrl;
  localparam int NC = 4;
  localparam int AW = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] core_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] cmd_m [NC];
  logic [31:0] mbx_m [NC];

  always #5 clk = ~clk;

  ipi_ctrl #(.NUM_CORES(NC), .ADDR_W(AW)) i_ipi_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq(core_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(int slot, int sel, output logic [31:0] v);
    bus_addr = AW'(slot * 8 + sel * 4);
    #1 v = bus_rdata;
  endtask

  task automatic verify_all(string req);
    logic [31:0] v;
    logic [NC-1:0] exp_irq;
    for (int s = 0; s < 8; s++) begin
      rd(s, 0, v); chk(req, v, (s < NC) ? cmd_m[s] : 32'h0);
      rd(s, 1, v); chk(req, v, (s < NC) ? mbx_m[s] : 32'h0);
    end
    for (int i = 0; i < NC; i++) exp_irq[i] = mbx_m[i][30];
    chk({req, "/R10"}, 32'(core_irq), 32'(exp_irq));
  endtask

  task automatic wr(int slot, int sel, logic [31:0] d);
    int dst;
    @(negedge clk);
    bus_addr = AW'(slot * 8 + sel * 4); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    if (slot < NC && sel == 0) begin
      cmd_m[slot] = d;
      dst = int'(d[29:16]);
      if (d[30] && dst < NC)
        mbx_m[dst] = (32'h1 << 30) | (32'(slot) << 16) | {16'h0, d[15:0]};
      if (d[31]) mbx_m[slot][30] = 1'b0;
    end
  endtask

  function automatic logic [31:0] cmd(bit clr, bit raise, int dst, int msg);
    return {clr, raise, 14'(dst), 16'(msg)};
  endfunction

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin cmd_m[i] = '0; mbx_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    verify_all("R1");

    // R2 full-word readback, no raise/clear bits
    for (int c = 0; c < NC; c++) begin
      wr(c, 0, 32'h3FFF_A5A5 ^ 32'(c * 32'h0001_1111));
      verify_all("R2");
    end

    // R3 / R5 / R4 sweep over sender, destination (incl. out of range), mode
    for (int s = 0; s < NC; s++)
      for (int d = 0; d < NC + 2; d++)
        for (int m = 0; m < 3; m++) begin
          wr(s, 0, cmd(m != 0, m != 2, d, s * 256 + d * 16 + m + 1));
          verify_all(m == 0 ? ((d < NC) ? "R3" : "R8") : (m == 1 ? "R5" : "R4"));
        end

    // R7 overwrite while pending
    wr(1, 0, cmd(0, 1, 2, 16'h1111));
    wr(3, 0, cmd(0, 1, 2, 16'h2222));
    chk("R7", 32'(core_irq[2]), 32'h1);
    verify_all("R7");

    // R8 far destinations
    wr(0, 0, cmd(0, 1, 4, 16'hBEEF));
    wr(0, 0, cmd(0, 1, 16383, 16'hCAFE));
    verify_all("R8");

    // R6 mailbox writes ignored
    for (int c = 0; c < NC; c++) begin
      wr(c, 1, 32'hFFFF_FFFF);
      verify_all("R6");
    end

    // R9 unmapped slots
    for (int s = NC; s < 8; s++) begin
      wr(s, 0, cmd(1, 1, 0, 16'h7777));
      verify_all("R9");
    end

    // R4 clear keeps sender/payload
    wr(0, 0, cmd(0, 1, 3, 16'h4242));
    wr(3, 0, cmd(1, 0, 0, 0));
    chk("R4", mbx_m[3], 32'h0000_4242);
    verify_all("R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule